// File: doc/BRIEF.md
# Glitch-Free Fast/Half-Rate Clock Selector

This block drives one of two clocks onto a single output. The first is a fast input clock. The second is a slower clock that the block derives from the fast one by division. Both clocks keep running while the choice changes, and a request to change the choice may arrive at any time and with any phase. The block moves its internal select only when both candidate clocks are low, so no runt pulse ever reaches the output.

The request first passes through a short synchroniser clocked on the falling edge of the fast clock. A gated launch register, also clocked on the falling edge, then takes the synchronised value. The register may load only at falling edges where the divided clock is low. At every other falling edge it keeps its old value. The divided clock changes only on rising edges of the fast clock. A falling edge with the divided clock low is therefore followed by a half period in which both clocks stay at 0, and the select changes inside that half period.

Top module: `clksel_glitchfree_mux`

## Requirements
- R1: While reset is asserted (rst_n low), the select output is 0, the divided clock is low and the muxed output is low.
- R2: The divided clock toggles once every DIV_HALF rising edges of the fast clock. With the default DIV_HALF=1 its period is twice the fast period (16 ns).
- R3: Select value 0 routes the divided clock to clk_out and select value 1 routes the fast clock. With the defaults, the clk_out period is 16 ns for select 0 and 8 ns for select 1.
- R4: The select output changes only on a falling edge of the fast clock at which the divided clock is low, so both clocks are at 0 when it changes.
- R5: A request level set between two fast falling edges is not visible on the select output before the third following falling edge. It is visible no later than the fourth.
- R6: clk_out never shows a high pulse shorter than half a fast-clock period (4 ns).
- R7: clk_out never shows a low pulse shorter than half a fast-clock period (4 ns).
- R8: A request pulse that begins and ends between two fast falling edges has no effect on the select output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_req | input | 1 | Asynchronous select request (1 = fast, 0 = divided) |
| clk_out | output | 1 | Muxed clock output |
| sel_now | output | 1 | Registered select that drives the mux |
| clk_div | output | 1 | Divided clock |

## Verification
A new request level reaches the select output through two synchroniser falling edges and then one gated falling edge. That gated edge may be skipped once if the divided clock is high, so the change is due at the third or fourth fast falling edge after the request. The driver changes the request 1 ns after a rising edge. It then samples the select 1 ns after the second falling edge, where the old value is expected, and again 1 ns after the fourth, where the new value is expected. A monitor checks each select change at the instant it happens against the expected value in the queue and against both clocks being low. Periods and pulse widths of clk_out are timed edge to edge, so they carry no latency at all.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic {
        SRC_DIV  = 1'b0,
        SRC_FAST = 1'b1
    } src_e;

endpackage

// File: rtl/clksel_divider.sv
module clksel_divider #(
    parameter int DIV_HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic clk_div
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          div;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.div = ~st_q.div;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_div = st_q.div;

    // checker: counts rising edges over which the output held its level
    logic          seen_q;
    logic [CW:0]   run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            run_q  <= '0;
        end else begin
            seen_q <= clk_div;
            if (clk_div != seen_q) run_q <= '0;
            else                   run_q <= run_q + 1'b1;
        end
    end

    a_r2_div_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (CW+1)'(DIV_HALF));

endmodule

// File: rtl/clksel_sel_launch.sv
module clksel_sel_launch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    input  logic div_level,
    output logic sel
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   sel;
    } launch_st_t;

    launch_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], req_async};
        // hold gating: a new value passes only while the divided clock is low
        if (!div_level) st_d.sel = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel = st_q.sel;

    // R4: a change seen now was loaded at the previous falling edge, where the divided clock was low
    a_r4_sel_moves_at_div_low: assert property (@(negedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> !$past(div_level));

    // R5: the select only ever takes the output of the last synchroniser stage
    a_r5_sel_from_sync: assert property (@(negedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> (sel == $past(st_q.sync[SYNC_STAGES-1])));

endmodule

// File: rtl/clksel_mux.sv
module clksel_mux (
    input  logic clk_src0,
    input  logic clk_src1,
    input  logic sel,
    output logic clk_o
);
    import clksel_pkg::*;

    always_comb begin
        case (src_e'(sel))
            SRC_FAST: clk_o = clk_src1;
            default:  clk_o = clk_src0;
        endcase
    end

endmodule

// File: rtl/clksel_glitchfree_mux.sv
module clksel_glitchfree_mux #(
    parameter int DIV_HALF    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_fast,
    input  logic rst_n,
    input  logic sel_req,
    output logic clk_out,
    output logic sel_now,
    output logic clk_div
);
    clksel_divider #(.DIV_HALF(DIV_HALF)) u_div (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .clk_div (clk_div)
    );

    clksel_sel_launch #(.SYNC_STAGES(SYNC_STAGES)) u_launch (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .req_async (sel_req),
        .div_level (clk_div),
        .sel       (sel_now)
    );

    clksel_mux u_mux (
        .clk_src0 (clk_div),
        .clk_src1 (clk_fast),
        .sel      (sel_now),
        .clk_o    (clk_out)
    );

    // R3: just before a fast falling edge the fast clock is high
    a_r3_fast_routed: assert property (@(negedge clk_fast) disable iff (!rst_n)
        sel_now |-> clk_out);

    a_r3_div_routed: assert property (@(negedge clk_fast) disable iff (!rst_n)
        !sel_now |-> (clk_out == clk_div));

endmodule

// File: tb/test_clksel_glitchfree_mux.sv
`timescale 1ns/1ps
module test_clksel_glitchfree_mux;
    logic clk_fast = 1'b0;
    logic rst_n    = 1'b0;
    logic sel_req  = 1'b0;
    logic clk_out, sel_now, clk_div;

    int checks   = 0;
    int failures = 0;
    bit mon_en   = 1'b0;
    bit done     = 1'b0;
    logic exp_q[$];
    logic cur_req = 1'b0;

    clksel_glitchfree_mux i_clksel_glitchfree_mux (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .sel_req  (sel_req),
        .clk_out  (clk_out),
        .sel_now  (sel_now),
        .clk_div  (clk_div)
    );

    always #4 clk_fast = ~clk_fast;

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // monitor: every select change must be expected and occur with both clocks low
    always @(sel_now) begin
        if (mon_en) begin
            logic e;
            check(clk_fast == 1'b0 && clk_div == 1'b0, "R4", "clocks at select change",
                  real'(clk_fast) + 2.0 * real'(clk_div), 0.0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected select change", real'(sel_now), real'(!sel_now));
            end else begin
                e = exp_q.pop_front();
                check(sel_now == e, "R5", "select value", real'(sel_now), real'(e));
            end
        end
    end

    // pulse width monitor on the muxed clock (R6, R7)
    realtime last_edge = 0.0;
    bit have_edge = 1'b0;
    always @(clk_out) begin
        if (mon_en) begin
            if (have_edge) begin
                if (clk_out) check(($realtime - last_edge) >= 3.999, "R7", "low pulse width",
                                   $realtime - last_edge, 4.0);
                else         check(($realtime - last_edge) >= 3.999, "R6", "high pulse width",
                                   $realtime - last_edge, 4.0);
            end
            have_edge = 1'b1;
            last_edge = $realtime;
        end
    end

    // driver: change the request 1 ns after a rising edge and check the latency window
    task automatic drive_req(input logic v);
        logic old;
        old = sel_now;
        @(posedge clk_fast); #1;
        if (v != cur_req) exp_q.push_back(v);
        cur_req = v;
        sel_req = v;
        @(negedge clk_fast); @(negedge clk_fast); #1;
        check(sel_now == old, "R5", "not before third falling edge", real'(sel_now), real'(old));
        @(negedge clk_fast); @(negedge clk_fast); #1;
        check(sel_now == v, "R5", "by fourth falling edge", real'(sel_now), real'(v));
    endtask

    task automatic measure_period(input bit use_div, input real exp, input string req);
        realtime t0;
        if (use_div) begin
            @(posedge clk_div); t0 = $realtime; @(posedge clk_div);
        end else begin
            @(posedge clk_out); t0 = $realtime; @(posedge clk_out);
        end
        check(($realtime - t0) > exp - 0.001 && ($realtime - t0) < exp + 0.001,
              req, "period", $realtime - t0, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk_fast);
        #1;
        // R1: reset state
        check(sel_now == 1'b0, "R1", "select in reset", real'(sel_now), 0.0);
        check(clk_div == 1'b0, "R1", "divided clock in reset", real'(clk_div), 0.0);
        check(clk_out == 1'b0, "R1", "output in reset", real'(clk_out), 0.0);
        @(negedge clk_fast); #2;
        rst_n  = 1'b1;
        mon_en = 1'b1;

        measure_period(1'b1, 16.0, "R2");
        measure_period(1'b0, 16.0, "R3");
        drive_req(1'b1);
        measure_period(1'b0, 8.0, "R3");

        // R8: short low pulse between falling edges is ignored
        @(posedge clk_fast); #1 sel_req = 1'b0; #2 sel_req = 1'b1;
        repeat (6) @(negedge clk_fast);
        #1;
        check(sel_now == 1'b1, "R8", "short pulse ignored", real'(sel_now), 1.0);

        drive_req(1'b0);
        measure_period(1'b0, 16.0, "R3");

        // R8: short high pulse while dividing
        @(posedge clk_fast); #1 sel_req = 1'b1; #2 sel_req = 1'b0;
        repeat (6) @(negedge clk_fast);
        #1;
        check(sel_now == 1'b0, "R8", "short pulse ignored", real'(sel_now), 0.0);

        // toggles at shifting phases against the divided clock
        for (int i = 0; i < 8; i++) begin
            repeat (i % 3) @(posedge clk_fast);
            drive_req(~cur_req);
        end
        measure_period(1'b1, 16.0, "R2");

        repeat (4) @(negedge clk_fast);
        check(exp_q.size() == 0, "R5", "queue drained", real'(exp_q.size()), 0.0);
        done = 1'b1;
        summary();
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

endmodule